// File: doc/BRIEF.md
# Interrupt Pending Register Bank

This block collects eight hardware interrupt sources into one pending register. A rising edge on a source request input latches that source's pending bit. Software sees the pending bits through a small register interface with an address, a write enable, write data and combinational read data. Through that interface software can read every pending bit at once, clear pending bits, or post interrupts itself.

The meaning of a write to the pending register depends on a software-post enable bit. With the enable low, a written 0 clears the matching bit and a written 1 does nothing. With the enable high, a written 1 posts the matching bit and a written 0 does nothing. A mask register gates the pending bits onto a single interrupt request to the CPU. A lowest-index-first picker reports which unmasked pending source would be served next. An acknowledge input clears that source, which models the separate vector-read clearing path.

The bank has no sequencer. The write mode is a two-value state, clear-mode or post-mode, held in the enable register. A reset puts it in clear-mode. Writing the enable register's bit 0 with 1 moves it to post-mode, and writing that bit with 0 moves it back to clear-mode.

Top module: `irq_pend_bank`

## Requirements
- R1: Source bits are laid out as follows: bit 0 voltage monitor, 1 analog, 2 touch sense, 3 timer0, 4 GPIO, 5 SPI, 6 sleep, 7 I2C. A 0-to-1 change on `src_req_i[k]` sets pending bit k on the next clock edge. A request that stays high does not set the bit again after the bit has been cleared.
- R2: A read at address 0xDA returns the 8-bit pending vector, with a 1 for every posted source.
- R3: In clear-mode (enable bit 0), a write to 0xDA clears every pending bit whose written bit is 0. Pending bits whose written bit is 1 are left unchanged.
- R4: In post-mode (enable bit 1), a write to 0xDA sets every pending bit whose written bit is 1. Pending bits whose written bit is 0 are left unchanged.
- R5: A rising source edge in the same cycle as a software clear of the same bit leaves that bit pending.
- R6: `irq_o` is 1 exactly when some bit is both pending and set in the mask register. Masking never stops a bit from becoming pending or from reading back as pending.
- R7: `pend_valid_o` is 1 when some bit is pending and unmasked. `pend_idx_o` then gives the lowest such bit number.
- R8: The mask register is at 0xE0 and is 8 bits read/write. The enable register is at 0xE1 and holds its only bit at bit 0. Its bits 7..1 read back as 0 whatever was written to them.
- R9: A one-cycle pulse on `ack_i` clears the pending bit named by `pend_idx_o` when `pend_valid_o` is 1. A source edge on that same bit in that cycle keeps the bit pending.
- R10: After reset the pending, mask and enable registers are all 0. A read at any other address returns 0, and a write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 8 | Hardware source requests, edge sensitive |
| bus_addr_i | input | 8 | Register address |
| bus_we_i | input | 1 | Write enable for the current address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current address, combinational |
| ack_i | input | 1 | Acknowledge; clears the reported pending source |
| irq_o | output | 1 | Interrupt request to the CPU |
| pend_idx_o | output | 3 | Lowest pending unmasked source number |
| pend_valid_o | output | 1 | pend_idx_o is meaningful |

## Verification
The hardest cases to reach from the ports are collisions, where a source's rising edge lands in exactly the cycle in which software or the acknowledge input clears that same bit. The stimulus brings the request low first, so that the next 0-to-1 change is a true edge. It then raises the request in the same driving step that starts a clearing write to the pending register, or the same step that asserts the acknowledge, so that both take effect at one clock edge. A request held high across a clear is also driven, to show that a steady level does not post the bit again.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    localparam int N_SRC = 8;
    localparam int ADDR_W = 8;
    localparam int IDX_W = $clog2(N_SRC);

    localparam logic [ADDR_W-1:0] ADDR_PEND = 8'hDA;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 8'hE0;
    localparam logic [ADDR_W-1:0] ADDR_SWEN = 8'hE1;

    typedef enum logic [IDX_W-1:0] {
        SRC_VMON   = 3'd0,
        SRC_ANALOG = 3'd1,
        SRC_TOUCH  = 3'd2,
        SRC_TIMER0 = 3'd3,
        SRC_GPIO   = 3'd4,
        SRC_SPI    = 3'd5,
        SRC_SLEEP  = 3'd6,
        SRC_I2C    = 3'd7
    } irq_src_e;

    typedef enum logic {
        WM_CLEAR = 1'b0,
        WM_POST  = 1'b1
    } wr_mode_e;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] req_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q[g] <= 1'b0;
            end else begin
                req_q[g] <= req_i[g];
            end
        end
        assign rise_o[g] = req_i[g] & ~req_q[g];
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  mask_i,
    output logic [IW-1:0] idx_o,
    output logic          valid_o
);

    logic [N-1:0] live;

    always_comb begin
        live    = pend_i & mask_i;
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) begin
                idx_o   = IW'(i);
                valid_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_pend_regs.sv
module irq_pend_regs
    import irq_pend_pkg::*;
#(
    parameter int N = N_SRC,
    parameter int AW = ADDR_W,
    parameter logic [AW-1:0] A_PEND = ADDR_PEND,
    parameter logic [AW-1:0] A_MASK = ADDR_MASK,
    parameter logic [AW-1:0] A_SWEN = ADDR_SWEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic [N-1:0]  wdata_i,
    input  logic [N-1:0]  hw_set_i,
    input  logic [N-1:0]  ack_clr_i,
    output logic [N-1:0]  pend_o,
    output logic [N-1:0]  mask_o,
    output logic          swen_o,
    output logic [N-1:0]  rdata_o
);

    logic [N-1:0] pend_q, pend_d;
    logic [N-1:0] mask_q;
    wr_mode_e     mode_q;
    logic [N-1:0] sw_set, sw_clr;
    logic         sel_pend;

    assign sel_pend = we_i && (addr_i == A_PEND);

    // Interpretation of a pending-register write depends on the mode state
    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        if (sel_pend) begin
            unique case (mode_q)
                WM_CLEAR: sw_clr = ~wdata_i;
                WM_POST:  sw_set = wdata_i;
            endcase
        end
    end

    // Set sources are applied after clears so a same-cycle edge survives
    assign pend_d = (pend_q & ~(sw_clr | ack_clr_i)) | sw_set | hw_set_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (we_i && (addr_i == A_MASK)) begin
            mask_q <= wdata_i;
        end
    end

    // Mode state: clear-mode after reset, bit 0 of the enable register moves it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= WM_CLEAR;
        end else if (we_i && (addr_i == A_SWEN)) begin
            mode_q <= wdata_i[0] ? WM_POST : WM_CLEAR;
        end
    end

    always_comb begin
        if (addr_i == A_PEND) begin
            rdata_o = pend_q;
        end else if (addr_i == A_MASK) begin
            rdata_o = mask_q;
        end else if (addr_i == A_SWEN) begin
            rdata_o = {{(N-1){1'b0}}, (mode_q == WM_POST)};
        end else begin
            rdata_o = '0;
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign swen_o = (mode_q == WM_POST);

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_pend_pkg::*;
#(
    parameter int N = N_SRC,
    parameter int AW = ADDR_W,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_req_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic          bus_we_i,
    input  logic [N-1:0]  bus_wdata_i,
    output logic [N-1:0]  bus_rdata_o,
    input  logic          ack_i,
    output logic          irq_o,
    output logic [IW-1:0] pend_idx_o,
    output logic          pend_valid_o
);

    logic [N-1:0] edge_w;
    logic [N-1:0] pend_q;
    logic [N-1:0] mask_q;
    logic         swen_q;
    logic [N-1:0] ack_clr;

    irq_edge_detect #(.N(N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (src_req_i),
        .rise_o (edge_w)
    );

    irq_pend_regs #(.N(N), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr_i),
        .we_i      (bus_we_i),
        .wdata_i   (bus_wdata_i),
        .hw_set_i  (edge_w),
        .ack_clr_i (ack_clr),
        .pend_o    (pend_q),
        .mask_o    (mask_q),
        .swen_o    (swen_q),
        .rdata_o   (bus_rdata_o)
    );

    irq_prio_pick #(.N(N)) u_pick (
        .pend_i  (pend_q),
        .mask_i  (mask_q),
        .idx_o   (pend_idx_o),
        .valid_o (pend_valid_o)
    );

    assign ack_clr = (ack_i && pend_valid_o) ? (N'(1) << pend_idx_o) : '0;
    assign irq_o   = |(pend_q & mask_q);

endmodule

// File: rtl/irq_pend_checker.sv
module irq_pend_checker #(
    parameter int N = 8,
    parameter int AW = 8,
    parameter logic [AW-1:0] A_PEND = 8'hDA,
    localparam int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr_i,
    input logic          bus_we_i,
    input logic [N-1:0]  bus_wdata_i,
    input logic          ack_i,
    input logic          swen_q,
    input logic [N-1:0]  pend_q,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  edge_w,
    input logic          irq_o,
    input logic [IW-1:0] pend_idx_o,
    input logic          pend_valid_o
);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == A_PEND && !swen_q && edge_w == '0 && !ack_i)
        |=> pend_q == ($past(pend_q) & $past(bus_wdata_i)));

    p_post_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == A_PEND && swen_q && !ack_i)
        |=> pend_q == ($past(pend_q) | $past(bus_wdata_i) | $past(edge_w)));

    p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_w != '0) |=> ((pend_q & $past(edge_w)) == $past(edge_w)));

    p_irq_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == pend_valid_o);

    p_idx_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o |-> (pend_q[pend_idx_o] && mask_q[pend_idx_o]));

endmodule

bind irq_pend_bank irq_pend_checker #(.N(N), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr_i   (bus_addr_i),
    .bus_we_i     (bus_we_i),
    .bus_wdata_i  (bus_wdata_i),
    .ack_i        (ack_i),
    .swen_q       (swen_q),
    .pend_q       (pend_q),
    .mask_q       (mask_q),
    .edge_w       (edge_w),
    .irq_o        (irq_o),
    .pend_idx_o   (pend_idx_o),
    .pend_valid_o (pend_valid_o)
);

// File: tb/irq_pend_bank_test.sv
module irq_pend_bank_test;

    localparam logic [7:0] A_PEND = 8'hDA;
    localparam logic [7:0] A_MASK = 8'hE0;
    localparam logic [7:0] A_SWEN = 8'hE1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_req = '0;
    logic [7:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ack = 1'b0;
    logic       irq;
    logic [2:0] pidx;
    logic       pvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_rd;
        logic [7:0] rd;
        logic       irq;
        logic       valid;
        logic [2:0] idx;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    irq_pend_bank uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_req_i    (src_req),
        .bus_addr_i   (bus_addr),
        .bus_we_i     (bus_we),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .ack_i        (ack),
        .irq_o        (irq),
        .pend_idx_o   (pidx),
        .pend_valid_o (pvalid)
    );

    // Monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.is_rd) begin
                if (bus_rdata !== e.rd) begin
                    errors++;
                    $display("FAIL %s: rdata=%h expected %h", e.tag, bus_rdata, e.rd);
                end
            end else begin
                if (irq !== e.irq || pvalid !== e.valid || (e.valid && pidx !== e.idx)) begin
                    errors++;
                    $display("FAIL %s: irq=%b valid=%b idx=%0d expected irq=%b valid=%b idx=%0d",
                             e.tag, irq, pvalid, pidx, e.irq, e.valid, e.idx);
                end
            end
        end
    end

    task automatic chk_rd(input logic [7:0] a, input logic [7:0] ex, input string tag);
        exp_t e;
        @(posedge clk); #1;
        bus_addr = a;
        e.is_rd = 1'b1; e.rd = ex; e.irq = 1'b0; e.valid = 1'b0; e.idx = '0; e.tag = tag;
        sb.push_back(e);
        @(negedge clk); #0.5;
    endtask

    task automatic chk_irq(input logic ei, input logic ev, input logic [2:0] ex, input string tag);
        exp_t e;
        @(posedge clk); #1;
        e.is_rd = 1'b0; e.rd = '0; e.irq = ei; e.valid = ev; e.idx = ex; e.tag = tag;
        sb.push_back(e);
        @(negedge clk); #0.5;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] bits);
        @(posedge clk); #1;
        src_req = src_req | bits;
        @(posedge clk); #1;
        src_req = src_req & ~bits;
    endtask

    task automatic ack_pulse(input logic [7:0] edge_bits);
        @(posedge clk); #1;
        ack = 1'b1; src_req = src_req | edge_bits;
        @(posedge clk); #1;
        ack = 1'b0; src_req = src_req & ~edge_bits;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        chk_rd(A_PEND, 8'h00, "R10 pending after reset");
        chk_rd(A_MASK, 8'h00, "R10 mask after reset");
        chk_rd(A_SWEN, 8'h00, "R10 enable after reset");
        chk_irq(1'b0, 1'b0, 3'd0, "R10 irq after reset");

        // R8 mask and enable registers, reserved bits
        wr(A_MASK, 8'hFF);
        chk_rd(A_MASK, 8'hFF, "R8 mask readback");
        wr(A_SWEN, 8'hFF);
        chk_rd(A_SWEN, 8'h01, "R8 enable reserved bits read 0");
        wr(A_SWEN, 8'h00);
        chk_rd(A_SWEN, 8'h00, "R8 enable cleared");

        // R1 R2 R6 R7 hardware posting (timer0 = bit 3)
        pulse(8'h08);
        chk_rd(A_PEND, 8'h08, "R1 R2 timer0 edge posts bit 3");
        chk_irq(1'b1, 1'b1, 3'd3, "R6 R7 irq and index 3");
        pulse(8'h22);
        chk_rd(A_PEND, 8'h2A, "R1 SPI and analog edges");
        chk_irq(1'b1, 1'b1, 3'd1, "R7 lowest index 1");

        // R1 held level does not repost; R3 clear with 0
        @(posedge clk); #1 src_req[6] = 1'b1;
        chk_rd(A_PEND, 8'h6A, "R1 sleep edge");
        wr(A_PEND, 8'hBF);
        chk_rd(A_PEND, 8'h2A, "R3 clear sleep bit");
        chk_rd(A_PEND, 8'h2A, "R1 held request does not repost");
        @(posedge clk); #1 src_req[6] = 1'b0;
        wr(A_PEND, 8'hDF);
        chk_rd(A_PEND, 8'h0A, "R3 clear SPI bit");
        wr(A_PEND, 8'hFF);
        chk_rd(A_PEND, 8'h0A, "R3 ones have no effect");

        // R4 post mode
        wr(A_SWEN, 8'h01);
        wr(A_PEND, 8'h00);
        chk_rd(A_PEND, 8'h0A, "R4 zeros ignored in post mode");
        wr(A_PEND, 8'h81);
        chk_rd(A_PEND, 8'h8B, "R4 ones post I2C and vmon");
        chk_irq(1'b1, 1'b1, 3'd0, "R7 index 0 after post");

        // R6 masking
        wr(A_MASK, 8'h00);
        chk_irq(1'b0, 1'b0, 3'd0, "R6 all masked");
        pulse(8'h04);
        chk_rd(A_PEND, 8'h8F, "R6 masked source still posts");
        wr(A_MASK, 8'h80);
        chk_irq(1'b1, 1'b1, 3'd7, "R7 only I2C unmasked");

        // R3 clear all
        wr(A_SWEN, 8'h00);
        wr(A_PEND, 8'h00);
        chk_rd(A_PEND, 8'h00, "R3 clear all");
        chk_irq(1'b0, 1'b0, 3'd0, "R6 irq drops");

        // R5 edge in same cycle as clear
        @(posedge clk); #1;
        src_req[4] = 1'b1; bus_addr = A_PEND; bus_we = 1'b1; bus_wdata = 8'h00;
        @(posedge clk); #1;
        bus_we = 1'b0; src_req[4] = 1'b0;
        chk_rd(A_PEND, 8'h10, "R5 GPIO edge beats clear");

        // R9 acknowledge path
        wr(A_MASK, 8'hFF);
        wr(A_SWEN, 8'h01);
        wr(A_PEND, 8'h05);
        chk_rd(A_PEND, 8'h15, "R4 post vmon and touch");
        chk_irq(1'b1, 1'b1, 3'd0, "R7 index 0");
        ack_pulse(8'h00);
        chk_rd(A_PEND, 8'h14, "R9 ack clears bit 0");
        chk_irq(1'b1, 1'b1, 3'd2, "R9 next index 2");
        ack_pulse(8'h00);
        chk_rd(A_PEND, 8'h10, "R9 ack clears bit 2");
        ack_pulse(8'h10);
        chk_rd(A_PEND, 8'h10, "R9 edge beats ack on bit 4");
        ack_pulse(8'h00);
        chk_rd(A_PEND, 8'h00, "R9 ack clears bit 4");
        chk_irq(1'b0, 1'b0, 3'd0, "R9 nothing left");

        // R10 other addresses
        wr(A_PEND, 8'h3C);
        wr(8'h55, 8'h00);
        chk_rd(8'h55, 8'h00, "R10 unknown address reads 0");
        chk_rd(A_PEND, 8'h3C, "R10 unknown write leaves pending");
        chk_rd(A_MASK, 8'hFF, "R10 unknown write leaves mask");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule